// File: doc/BRIEF.md
# Shift and Sign-Extend Unit

This block is the shift section of a 32-bit integer execution stage, and it is purely combinational. It has two kinds of shift. The first is a barrel shifter that moves the operand right (with zero or sign fill) or left by any distance from 0 to 31. The distance comes either from a register operand or from an instruction immediate. The second kind is a group of one-bit right shifts that drop operand bit 0 into the carry flag. Each of these fills the vacated top bit in its own way: with the sign, with the previous carry, or with zero. The block also widens a signed byte or a signed halfword to the full word.

The carry flag lives outside the unit. The current flag value enters on `carryIn`. The unit returns the new value on `carryOut` and raises `carryWe` whenever the flag must be written. A small decoder turns the 4-bit operation code into a struct of strobes, and a datapath module consumes those strobes.

Top module: `shift_sext_unit`

## Requirements
- R1: Operation code 0 gives a logical right shift of `opA` by the shift distance, filling with zeros.
- R2: Operation code 1 gives an arithmetic right shift of `opA` by the shift distance, copying bit 31 into every vacated bit.
- R3: Operation code 2 gives a logical left shift of `opA` by the shift distance, filling with zeros.
- R4: The shift distance is `immVal[4:0]` when `useImm` is 1 and `opB[4:0]` when `useImm` is 0. All higher bits of both sources are ignored, so a distance of 32 or more acts modulo 32.
- R5: Operation code 3 returns `opA` shifted right by one bit, with bit 31 kept equal to the old bit 31.
- R6: Operation code 4 returns `opA` shifted right by one bit, with `carryIn` placed into bit 31.
- R7: Operation code 5 returns `opA` shifted right by one bit, with bit 31 forced to 0.
- R8: For operation codes 3, 4 and 5, `carryWe` is 1 and `carryOut` equals `opA[0]`.
- R9: For operation codes 0, 1, 2, 6 and 7, `carryWe` is 0 and `carryOut` equals `carryIn`.
- R10: Operation code 6 returns `opA[7:0]` with bit 7 copied across bits 31:8.
- R11: Operation code 7 returns `opA[15:0]` with bit 15 copied across bits 31:16.
- R12: Operation codes 8 to 15 return `opA` unchanged, with `carryWe` 0 and `carryOut` equal to `carryIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 4 | Operation code (see R1 to R12) |
| opA | input | 32 | Operand to shift or extend |
| opB | input | 32 | Register source of the shift distance |
| immVal | input | 16 | Immediate source of the shift distance |
| useImm | input | 1 | Selects the immediate as the distance source |
| carryIn | input | 1 | Current carry flag |
| result | output | 32 | Shifted or extended value |
| carryOut | output | 1 | Next carry flag value |
| carryWe | output | 1 | Carry flag write enable |

## Verification
Assertions are evaluated whenever the inputs change. They cover the carry rules (`carryWe` only for the one-bit shifts, a kept flag otherwise, bit 0 landing in the flag), the mutual exclusion of the decoded strobes, the top-bit rule of the shift-through-carry, and the uniform upper bits of both sign extensions. Only the bench's sweeps can show the data result of the barrel shifter: every distance in every barrel mode, from both distance sources, with junk in the ignored upper bits. The one-bit shifts are checked with the flag both set and clear.

// File: rtl/shu_pkg.sv
package shu_pkg;

  typedef enum logic [3:0] {
    OP_SHR_LOG  = 4'd0,
    OP_SHR_ARI  = 4'd1,
    OP_SHL_LOG  = 4'd2,
    OP_ONE_ARI  = 4'd3,
    OP_ONE_CRY  = 4'd4,
    OP_ONE_LOG  = 4'd5,
    OP_EXT_BYTE = 4'd6,
    OP_EXT_HALF = 4'd7
  } shu_op_e;

  typedef enum logic [1:0] {
    FILL_SIGN  = 2'd0,
    FILL_CARRY = 2'd1,
    FILL_ZERO  = 2'd2
  } shu_fill_e;

  typedef struct packed {
    logic      barrel;
    logic      toLeft;
    logic      arith;
    logic      single;
    shu_fill_e topFill;
    logic      extByte;
    logic      extHalf;
    logic      writeCarry;
    logic      useImm;
  } shu_strobe_t;

endpackage

// File: rtl/shu_ctrl.sv
module shu_ctrl
  import shu_pkg::*;
(
  input  logic [3:0]  opSel,
  input  logic        useImm,
  output shu_strobe_t strb
);

  always_comb begin
    strb            = '0;
    strb.topFill    = FILL_ZERO;
    strb.useImm     = useImm;
    case (opSel)
      OP_SHR_LOG: strb.barrel = 1'b1;
      OP_SHR_ARI: begin
        strb.barrel = 1'b1;
        strb.arith  = 1'b1;
      end
      OP_SHL_LOG: begin
        strb.barrel = 1'b1;
        strb.toLeft = 1'b1;
      end
      OP_ONE_ARI: begin
        strb.single     = 1'b1;
        strb.topFill    = FILL_SIGN;
        strb.writeCarry = 1'b1;
      end
      OP_ONE_CRY: begin
        strb.single     = 1'b1;
        strb.topFill    = FILL_CARRY;
        strb.writeCarry = 1'b1;
      end
      OP_ONE_LOG: begin
        strb.single     = 1'b1;
        strb.topFill    = FILL_ZERO;
        strb.writeCarry = 1'b1;
      end
      OP_EXT_BYTE: strb.extByte = 1'b1;
      OP_EXT_HALF: strb.extHalf = 1'b1;
      default: ;
    endcase
  end

  // decoded strobes select at most one result source
  always_comb begin
    p_strobe_excl_r12: assert ($onehot0({strb.barrel, strb.single, strb.extByte, strb.extHalf}));
    // carry write only for the one-bit shifts
    p_we_single_r8: assert (!strb.writeCarry || strb.single);
    // left and arithmetic qualifiers only with the barrel shifter
    p_qual_barrel_r3: assert (strb.barrel || !(strb.toLeft || strb.arith));
  end

endmodule

// File: rtl/shu_datapath.sv
module shu_datapath
  import shu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  shu_strobe_t       strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   shAmt;
  logic              unusedAmtBits;
  logic              barrelFill;
  logic [DATA_W-1:0] revIn;
  logic [DATA_W-1:0] revOut;
  logic [DATA_W-1:0] stage [SH_W+1];
  logic [DATA_W-1:0] barrelRes;
  logic              topBit;
  logic [DATA_W-1:0] oneRes;
  logic [DATA_W-1:0] extByteRes;
  logic [DATA_W-1:0] extHalfRes;

  // distance source: only the low SH_W bits count
  assign shAmt         = strb.useImm ? immVal[SH_W-1:0] : opB[SH_W-1:0];
  assign unusedAmtBits = ^{opB[DATA_W-1:SH_W], immVal[IMM_W-1:SH_W]};

  assign barrelFill = strb.arith & opA[DATA_W-1];

  // left shifts reuse the right shifter on a bit-reversed word
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign revIn[i]  = opA[DATA_W-1-i];
    assign revOut[i] = stage[SH_W][DATA_W-1-i];
  end

  assign stage[0] = strb.toLeft ? revIn : opA;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 2 ** k;
    assign stage[k+1] = shAmt[k] ? {{STEP{barrelFill}}, stage[k][DATA_W-1:STEP]}
                                 : stage[k];
  end

  assign barrelRes = strb.toLeft ? revOut : stage[SH_W];

  always_comb begin
    case (strb.topFill)
      FILL_SIGN:  topBit = opA[DATA_W-1];
      FILL_CARRY: topBit = carryIn;
      default:    topBit = 1'b0;
    endcase
  end

  assign oneRes     = {topBit, opA[DATA_W-1:1]};
  assign extByteRes = {{(DATA_W-8){opA[7]}}, opA[7:0]};
  assign extHalfRes = {{(DATA_W-16){opA[15]}}, opA[15:0]};

  always_comb begin
    if (strb.barrel)       result = barrelRes;
    else if (strb.single)  result = oneRes;
    else if (strb.extByte) result = extByteRes;
    else if (strb.extHalf) result = extHalfRes;
    else                   result = opA;
  end

  assign carryOut = strb.writeCarry ? opA[0] : carryIn;

  always_comb begin
    if (strb.single) begin
      p_bit0_to_carry_r8: assert (carryOut == opA[0]);
      p_low_bits_r5: assert (result[DATA_W-2:0] == opA[DATA_W-1:1]);
    end
    if (!strb.single) begin
      p_carry_kept_r9: assert (carryOut == carryIn);
    end
    if (strb.single && strb.topFill == FILL_CARRY) begin
      p_carry_top_r6: assert (result[DATA_W-1] == carryIn);
    end
    if (strb.barrel && shAmt == '0) begin
      p_zero_dist_r4: assert (result == opA);
    end
    if (strb.extByte) begin
      p_ext_byte_r10: assert (result[DATA_W-1:8] == '0 || result[DATA_W-1:8] == '1);
    end
    if (strb.extHalf) begin
      p_ext_half_r11: assert (result[DATA_W-1:16] == '0 || result[DATA_W-1:16] == '1);
    end
  end

endmodule

// File: rtl/shift_sext_unit.sv
module shift_sext_unit
  import shu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              useImm,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              carryWe
);

  shu_strobe_t strb;

  shu_ctrl u_ctrl (
    .opSel  (opSel),
    .useImm (useImm),
    .strb   (strb)
  );

  shu_datapath #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_dp (
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .immVal   (immVal),
    .carryIn  (carryIn),
    .result   (result),
    .carryOut (carryOut)
  );

  assign carryWe = strb.writeCarry;

  // only codes 3..5 may request a carry write
  always_comb begin
    if (carryWe) begin
      p_we_codes_r8: assert (opSel >= 4'd3 && opSel <= 4'd5);
    end
  end

endmodule

// File: tb/sim_shift_sext_unit.sv
module sim_shift_sext_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opSel = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] immVal = '0;
  logic        useImm = 1'b0;
  logic        carryIn = 1'b0;
  logic [31:0] result;
  logic        carryOut;
  logic        carryWe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shift_sext_unit u0 (
    .opSel(opSel), .opA(opA), .opB(opB), .immVal(immVal), .useImm(useImm),
    .carryIn(carryIn), .result(result), .carryOut(carryOut), .carryWe(carryWe)
  );

  task automatic chk(input string req, input logic [31:0] expR,
                     input logic expC, input logic expW);
    checks++;
    if (result !== expR || carryOut !== expC || carryWe !== expW) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h ui=%0b ci=%0b : got r=%h c=%0b w=%0b exp r=%h c=%0b w=%0b",
               req, opSel, opA, opB, immVal, useImm, carryIn,
               result, carryOut, carryWe, expR, expC, expW);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm,
                       input logic ui, input logic ci);
    @(negedge clk);
    opSel = op; opA = a; opB = b; immVal = imm; useImm = ui; carryIn = ci;
    #2;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, exp completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] data [4];
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // reset-state style check: idle inputs give zero outputs (R1)
    apply(4'd0, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0);
    chk("R1 idle", 32'h0, 1'b0, 1'b0);

    // barrel modes, every distance, both sources, junk upper bits (R1 R2 R3 R4 R9)
    for (int d = 0; d < 4; d++) data[d] = $urandom();
    data[0] = 32'h8000_0001;
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 32; s++) begin
        for (int d = 0; d < 4; d++) begin
          for (int ui = 0; ui < 2; ui++) begin
            logic [31:0] a, exp, b;
            logic [15:0] imm;
            logic ci;
            a   = data[d];
            ci  = d[0];
            b   = ({$urandom()} & 32'hFFFF_FFE0) | 32'(s);
            imm = ({$urandom()} & 16'hFFE0) | 16'(s);
            if (ui == 1) b = $urandom();
            else imm = 16'($urandom());
            case (m)
              0: exp = a >> s;
              1: exp = 32'($signed(a) >>> s);
              default: exp = a << s;
            endcase
            apply(4'(m), a, b, imm, ui[0], ci);
            if (m == 0) chk("R1 R4 R9 shr", exp, ci, 1'b0);
            else if (m == 1) chk("R2 R4 R9 sar", exp, ci, 1'b0);
            else chk("R3 R4 R9 shl", exp, ci, 1'b0);
          end
        end
      end
    end

    // distance 32 and 33 wrap modulo 32 (R4)
    apply(4'd0, 32'hF000_000F, 32'd32, 16'h0, 1'b0, 1'b0);
    chk("R4 wrap32", 32'hF000_000F, 1'b0, 1'b0);
    apply(4'd2, 32'h0000_0003, 32'h0, 16'd33, 1'b1, 1'b1);
    chk("R4 wrap33", 32'h0000_0006, 1'b1, 1'b0);

    // one-bit shifts with carry clear and set (R5 R6 R7 R8)
    for (int ci = 0; ci < 2; ci++) begin
      for (int d = 0; d < 16; d++) begin
        logic [31:0] a;
        a = (d < 4) ? {d[1], 30'h1555_5555, d[0]} : $urandom();
        apply(4'd3, a, 32'h0, 16'h0, 1'b0, ci[0]);
        chk("R5 R8 sar1", {a[31], a[31:1]}, a[0], 1'b1);
        apply(4'd4, a, 32'h0, 16'h0, 1'b0, ci[0]);
        chk("R6 R8 src1", {ci[0], a[31:1]}, a[0], 1'b1);
        apply(4'd5, a, 32'h0, 16'h0, 1'b0, ci[0]);
        chk("R7 R8 srl1", {1'b0, a[31:1]}, a[0], 1'b1);
      end
    end

    // sign extension boundaries and random (R10 R11 R9)
    begin
      logic [31:0] pat [6];
      pat[0] = 32'hFFFF_FF7F; pat[1] = 32'h0000_0080; pat[2] = 32'h1234_7FFF;
      pat[3] = 32'h0000_8000; pat[4] = $urandom();    pat[5] = $urandom();
      for (int p = 0; p < 6; p++) begin
        for (int ci = 0; ci < 2; ci++) begin
          apply(4'd6, pat[p], 32'h0, 16'h0, 1'b0, ci[0]);
          chk("R10 R9 ext8", {{24{pat[p][7]}}, pat[p][7:0]}, ci[0], 1'b0);
          apply(4'd7, pat[p], 32'h0, 16'h0, 1'b0, ci[0]);
          chk("R11 R9 ext16", {{16{pat[p][15]}}, pat[p][15:0]}, ci[0], 1'b0);
        end
      end
    end

    // unused codes pass the operand through (R12)
    for (int op = 8; op < 16; op++) begin
      for (int ci = 0; ci < 2; ci++) begin
        logic [31:0] a;
        a = $urandom() | 32'h1;
        apply(4'(op), a, 32'h3, 16'h3, ci[0], ci[0]);
        chk("R12 unused", a, ci[0], 1'b0);
      end
    end

    done = 1'b1;
    finish_run();
  end

endmodule